// File: doc/BRIEF.md
# Programmable Down-Counting Timer Channel

This block is one channel of a 32-bit down-counting timer that software drives through a small register bus. Software picks one of four tick sources, writes a reload value, optionally enables the interrupt, and then starts the channel. The counter is loaded when the channel starts. From then on, every tick from the chosen source takes one off the count. A tick that arrives while the count is zero reloads the counter and raises a sticky status flag. The interrupt line follows that flag, gated by the interrupt enable.

Each tick source arrives as a one-cycle enable pulse in the system clock domain, so the channel never switches clocks. The four sources are a slow 32 kHz tick, a 26 MHz tick, a tick derived from the bus clock and a peripheral-clock tick. The reload value and the interrupt enable are frozen while the channel runs, which keeps a live countdown consistent. The source select, the status clear and the count readback stay usable at all times. Several channels can be placed side by side, each with its own copy of this block.

Top module: `cdt_channel`

## Requirements
- R1: After reset the channel is stopped, the interrupt enable and status are 0, the reload register and the count both read all ones, the source field reads 0 and irq_o is 0.
- R2: Writing 1 to run (bit 0 of the control word, address 0) while stopped loads the count from the reload register. While running, each tick_i pulse on the selected source (control bits 2:1; 0 = 32 kHz, 1 = 26 MHz, 2 = bus-derived, 3 = peripheral; tick_i bit index equals the code) lowers the count by 1. Pulses on the other sources do nothing.
- R3: Writes to the reload register (address 2) are ignored while the channel runs. They take effect while it is stopped.
- R4: Writes to the interrupt-enable bit (bit 0 of the interrupt word, address 1) are ignored while the channel runs.
- R5: A selected tick that arrives while the count is 0 reloads the count from the reload register and sets the status flag (bit 1 of the interrupt word).
- R6: Writing a 1 to bit 2 of the interrupt word clears the status flag. Writing 0 there leaves it unchanged. Bit 2 always reads 0.
- R7: When an expiry and a status-clear write fall in the same cycle, the status flag ends up set.
- R8: irq_o equals status AND interrupt-enable as they stood one cycle earlier.
- R9: The count (address 3) can be read at any time, with read data valid one cycle after the address. Stopping the channel holds the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the address of the previous cycle |
| tick_i | input | 4 | One-cycle tick enables, one per source |
| irq_o | output | 1 | Registered interrupt request |

## Verification
An expiry, which sets the status flag, can fall in the same cycle as a software write that clears it. The bench provokes this by presenting a status-clear write and a selected tick in a single cycle while the count sits at zero with a reload of zero. The status bit must still read 1 afterwards and irq_o must stay high. A separate write of the clear bit, made with no tick, must then bring both down. The same cases are checked for starting the channel in a cycle that also carries a tick: the load wins and that tick has no effect.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int REG_AW = 2;

  localparam logic [REG_AW-1:0] A_CTRL   = 2'd0;
  localparam logic [REG_AW-1:0] A_IRQ    = 2'd1;
  localparam logic [REG_AW-1:0] A_RELOAD = 2'd2;
  localparam logic [REG_AW-1:0] A_COUNT  = 2'd3;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_SRC_LSB = 1;
  localparam int IRQ_IE_BIT   = 0;
  localparam int IRQ_STAT_BIT = 1;
  localparam int IRQ_CLR_BIT  = 2;

  typedef enum logic [1:0] {
    SRC_SLOW   = 2'd0,
    SRC_FAST   = 2'd1,
    SRC_BUS    = 2'd2,
    SRC_PERIPH = 2'd3
  } tick_src_e;
endpackage

// File: rtl/cdt_tick_sel.sv
module cdt_tick_sel #(
  parameter int NUM_SRC = 4,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] ticks,
  input  logic [SRC_W-1:0]   sel,
  output logic               tick
);
  logic [NUM_SRC-1:0] hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hit[i] = ticks[i] & (sel == SRC_W'(i));
  end

  assign tick = |hit;
endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SRC_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              expire,
  output logic              run_q,
  output logic [SRC_W-1:0]  src_q,
  output logic              ie_q,
  output logic              status_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic              start
);
  logic wr_ctrl, wr_irq, wr_reload;

  assign wr_ctrl   = wr_en && (addr == A_CTRL);
  assign wr_irq    = wr_en && (addr == A_IRQ);
  assign wr_reload = wr_en && (addr == A_RELOAD);
  assign start     = wr_ctrl && wdata[CTRL_RUN_BIT] && !run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      src_q <= '0;
    end else if (wr_ctrl) begin
      run_q <= wdata[CTRL_RUN_BIT];
      src_q <= wdata[CTRL_SRC_LSB +: SRC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q <= 1'b0;
    end else if (wr_irq && !run_q) begin
      ie_q <= wdata[IRQ_IE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 1'b0;
    end else if (expire) begin
      status_q <= 1'b1;
    end else if (wr_irq && wdata[IRQ_CLR_BIT]) begin
      status_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '1;
    end else if (wr_reload && !run_q) begin
      reload_q <= wdata;
    end
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count_q,
  output logic             expire
);
  logic at_zero;

  assign at_zero = (count_q == '0);
  assign expire  = run && tick && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '1;
    end else if (start) begin
      count_q <= reload;
    end else if (run && tick) begin
      count_q <= at_zero ? reload : count_q - 1'b1;
    end
  end
endmodule

// File: rtl/cdt_channel.sv
module cdt_channel
  import cdt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [REG_AW-1:0]  addr,
  input  logic [CNT_W-1:0]   wdata,
  output logic [CNT_W-1:0]   rdata,
  input  logic [NUM_SRC-1:0] tick_i,
  output logic               irq_o
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic             run_q, ie_q, status_q, start, sel_tick, expire;
  logic [SRC_W-1:0] src_q;
  logic [CNT_W-1:0] reload_q, count_q, rd_mux;

  cdt_tick_sel #(.NUM_SRC(NUM_SRC)) u_sel (
    .ticks(tick_i),
    .sel  (src_q),
    .tick (sel_tick)
  );

  cdt_regs #(.CNT_W(CNT_W), .SRC_W(SRC_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .expire  (expire),
    .run_q   (run_q),
    .src_q   (src_q),
    .ie_q    (ie_q),
    .status_q(status_q),
    .reload_q(reload_q),
    .start   (start)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .run    (run_q),
    .tick   (sel_tick),
    .reload (reload_q),
    .count_q(count_q),
    .expire (expire)
  );

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      A_CTRL: begin
        rd_mux[CTRL_RUN_BIT]              = run_q;
        rd_mux[CTRL_SRC_LSB +: SRC_W]     = src_q;
      end
      A_IRQ: begin
        rd_mux[IRQ_IE_BIT]   = ie_q;
        rd_mux[IRQ_STAT_BIT] = status_q;
      end
      A_RELOAD: rd_mux = reload_q;
      default:  rd_mux = count_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq_o <= 1'b0;
    end else begin
      rdata <= rd_mux;
      irq_o <= status_q && ie_q;
    end
  end
endmodule

// File: rtl/cdt_channel_chk.sv
module cdt_channel_chk #(
  parameter int CNT_W = 32,
  parameter int SRC_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic             run_q,
  input logic             ie_q,
  input logic             status_q,
  input logic             sel_tick,
  input logic [CNT_W-1:0] reload_q,
  input logic [CNT_W-1:0] count_q,
  input logic             irq_o
);
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(status_q && ie_q))); // R8

  AST_RELOAD_LOCKED: assert property (@(posedge clk) disable iff (rst)
    run_q |=> $stable(reload_q)); // R3

  AST_IE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    run_q |=> $stable(ie_q)); // R4

  AST_EXPIRE_RELOADS: assert property (@(posedge clk) disable iff (rst)
    (run_q && sel_tick && count_q == '0) |=> (status_q && count_q == $past(reload_q))); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run_q && sel_tick && count_q != '0) |=> (count_q == $past(count_q) - 1'b1)); // R2

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !(wr_en && addr == 2'd0)) |=> $stable(count_q)); // R9
endmodule

bind cdt_channel cdt_channel_chk #(.CNT_W(CNT_W), .SRC_W(SRC_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .addr    (addr),
  .run_q   (run_q),
  .ie_q    (ie_q),
  .status_q(status_q),
  .sel_tick(sel_tick),
  .reload_q(reload_q),
  .count_q (count_q),
  .irq_o   (irq_o)
);

// File: tb/cdt_channel_tb.sv
`timescale 1ns/1ps
module cdt_channel_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  tick_i = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cdt_channel u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick_i(tick_i), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [31:0] reload;
    logic [1:0]  src;
    logic [7:0]  n;
    logic [31:0] exp_cnt;
    logic        exp_st;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'd10,        2'd0, 8'd3, 32'd7,         1'b0},
    '{32'd5,         2'd1, 8'd5, 32'd0,         1'b0},
    '{32'd5,         2'd2, 8'd6, 32'd5,         1'b1},
    '{32'd0,         2'd3, 8'd1, 32'd0,         1'b1},
    '{32'd3,         2'd1, 8'd9, 32'd2,         1'b1},
    '{32'hFFFFFFFF,  2'd0, 8'd2, 32'hFFFFFFFD,  1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk);
    tick_i = m;
    @(negedge clk);
    tick_i = '0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 32'd0);
    rd(2'd1, v); check("R1 irq word", v, 32'd0);
    rd(2'd2, v); check("R1 reload", v, 32'hFFFFFFFF);
    rd(2'd3, v); check("R1 count", v, 32'hFFFFFFFF);
    check("R1 irq_o", {31'd0, irq_o}, 32'd0);

    // R2 R5 vector table
    foreach (VECS[i]) begin
      wr(2'd0, 32'd0);
      wr(2'd1, 32'd4);
      wr(2'd2, VECS[i].reload);
      wr(2'd0, {29'd0, VECS[i].src, 1'b1});
      for (int k = 0; k < int'(VECS[i].n); k++) begin
        pulse(4'b0001 << VECS[i].src);
        pulse(~(4'b0001 << VECS[i].src));
      end
      rd(2'd3, v); check("R2 R5 count", v, VECS[i].exp_cnt);
      rd(2'd1, v); check("R5 status", {31'd0, v[1]}, {31'd0, VECS[i].exp_st});
    end

    // R9 hold when stopped, R2 restart reloads
    wr(2'd0, 32'd0);
    wr(2'd2, 32'd20);
    wr(2'd0, 32'd5);
    repeat (3) pulse(4'b0100);
    rd(2'd3, v); check("R9 live count", v, 32'd17);
    wr(2'd0, 32'd4);
    repeat (2) pulse(4'b0100);
    rd(2'd3, v); check("R9 held count", v, 32'd17);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd0; wdata = 32'd5; tick_i = 4'b0100;
    @(negedge clk);
    wr_en = 1'b0; tick_i = '0;
    rd(2'd3, v); check("R2 start load beats tick", v, 32'd20);

    // R3 R4 locks
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd5);
    wr(2'd2, 32'd0);
    wr(2'd0, 32'd1);
    wr(2'd1, 32'd0);
    rd(2'd1, v); check("R4 ie locked", {31'd0, v[0]}, 32'd1);
    wr(2'd2, 32'd99);
    rd(2'd2, v); check("R3 reload locked", v, 32'd0);

    // R5 R8 expiry raises irq
    pulse(4'b0001);
    rd(2'd1, v); check("R5 status set", {31'd0, v[1]}, 32'd1);
    check("R8 irq high", {31'd0, irq_o}, 32'd1);

    // R6 writing 0 to clear bit has no effect
    wr(2'd1, 32'd0);
    rd(2'd1, v); check("R6 zero write keeps status", {31'd0, v[1]}, 32'd1);
    check("R6 clear bit reads 0", {31'd0, v[2]}, 32'd0);

    // R7 expiry and clear in the same cycle
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd1; wdata = 32'd4; tick_i = 4'b0001;
    @(negedge clk);
    wr_en = 1'b0; tick_i = '0;
    rd(2'd1, v); check("R7 expiry beats clear", {31'd0, v[1]}, 32'd1);
    check("R8 irq held", {31'd0, irq_o}, 32'd1);

    // R6 R8 clear alone
    wr(2'd1, 32'd4);
    rd(2'd1, v); check("R6 status cleared", {31'd0, v[1]}, 32'd0);
    check("R8 irq low", {31'd0, irq_o}, 32'd0);

    // R3 reload writable once stopped
    wr(2'd0, 32'd0);
    wr(2'd2, 32'd99);
    rd(2'd2, v); check("R3 reload when stopped", v, 32'd99);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule